// File: doc/BRIEF.md
# I2C Register Slave with Group-Wrapping Pointer

This block lets an I2C bus master read and write a 64-byte register file that lives outside it. The bus lines are oversampled by a fast system clock through two-flop synchronizers. START and STOP conditions, the 7-bit device address, the byte shifting (MSB first) and the acknowledge handshake are all handled inside. Register writes leave the block as a single-cycle strobe carrying an address and a data byte. Read data enters combinationally from the register file at the address the block presents.

A register pointer selects the register being accessed. In a write transaction, the first byte after the device address loads the pointer. Every following byte is written to the pointer's location, and the pointer then steps forward. A read transaction sends bytes starting at the pointer. The step wraps inside the current 16-register group: only the low four pointer bits count, so the location after 0x2F is 0x20. The pointer survives between transactions. This means a read that skips the pointer write continues right after the last register touched. A random read loads the pointer with a write, then issues a repeated START and the read address.

Top module: `twi_regslave`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR (default 0x32, so 0x64 selects write and 0x65 selects read; bit 0 is the direction, 1 = read) is acknowledged by pulling SDA low in the ninth clock. Any other address gets no ACK. The block then ignores the bus (no ACK, no write) until the next START.
- R2: In a write transaction, the first byte after the address is acknowledged. Its low six bits load the register pointer, and its upper two bits are ignored.
- R3: Each later byte of a write transaction is acknowledged. It produces one write strobe with the current pointer as address and the byte as data. The pointer then advances.
- R4: Pointer advance keeps bits [5:4] and adds one to bits [3:0] modulo 16, so 0x1F→0x10, 0x2F→0x20 and 0x3F→0x30.
- R5: After a pointer write, a repeated START (no STOP) and a read address make the block send the byte at that pointer first, MSB first.
- R6: While the master answers each read byte with ACK (SDA low), the block sends the byte at the next pointer location, advancing by the R4 rule after every byte sent.
- R7: After the master answers a read byte with NACK (SDA high), the block releases SDA and drives nothing further until a START.
- R8: A read that starts directly with a read address returns, as its first byte, the register that follows the last register written or read.
- R9: After reset, SDA is released, no write strobe is active and the pointer holds 0x10.
- R10: A STOP or START arriving in the middle of a byte abandons it. A partly received byte causes no write, and the pointer keeps its value.
- R11: The SDA drive changes only while the synchronized SCL is low, except for the release caused by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| wr_en_o | output | 1 | Single-cycle register write strobe |
| wr_addr_o | output | ADDR_W | Register address for the write |
| wr_data_o | output | 8 | Register data for the write |
| rd_addr_o | output | ADDR_W | Register address being read (the pointer) |
| rd_data_i | input | 8 | Combinational read data for rd_addr_o |

## Verification
The bench targets several wrap points:
- Writes at 0x1E and 0x3F: a linearly counting pointer would spill into the next group.
- Reads across 0x2F: a linearly counting pointer would return 0x30 instead of 0x20.

It aborts a byte with a STOP and with a repeated START. A design that commits partial bytes or moves the pointer on an abort would show a stray write, or a shifted current-address read. After a master NACK it clocks a further byte and expects all ones back. A slave that kept transmitting would pull bits low. A foreign address followed by data bytes must draw neither ACKs nor write strobes.

// File: rtl/twi_pkg.sv
package twi_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_PTR,
      ST_PTR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } twi_state_e;

   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } twi_evt_t;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   localparam int CHAIN_W = WIDTH * STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("twi_sync needs at least two stages");
   end

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
   end

   assign q_o = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/twi_busmon.sv
module twi_busmon
   import twi_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output twi_evt_t evt_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      evt_o.scl_rise = scl_s & ~scl_q;
      evt_o.scl_fall = ~scl_s & scl_q;
      evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
      evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
   end
endmodule

// File: rtl/twi_ptr.sv
module twi_ptr #(
   parameter int                ADDR_W  = 6,
   parameter int                GROUP_W = 4,
   parameter logic [ADDR_W-1:0] RST_PTR = 6'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   input  logic              inc_i,
   output logic [ADDR_W-1:0] ptr_o
);
   logic [ADDR_W-1:0] ptr_q, ptr_step;

   if (GROUP_W < 1 || GROUP_W > ADDR_W) begin : g_bad_group
      $error("twi_ptr GROUP_W must lie in 1..ADDR_W");
   end

   if (GROUP_W == ADDR_W) begin : g_linear
      assign ptr_step = ptr_q + ADDR_W'(1);
   end else begin : g_group
      assign ptr_step = {ptr_q[ADDR_W-1:GROUP_W], ptr_q[GROUP_W-1:0] + GROUP_W'(1)};

      a_r4_group_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (inc_i && !load_i) |=> ptr_q[ADDR_W-1:GROUP_W] == $past(ptr_q[ADDR_W-1:GROUP_W]));

      a_r4_low_wraps: assert property (@(posedge clk) disable iff (!rst_n)
         (inc_i && !load_i && (&ptr_q[GROUP_W-1:0])) |=> (ptr_q[GROUP_W-1:0] == '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= RST_PTR;
      else if (load_i) ptr_q <= load_val_i;
      else if (inc_i)  ptr_q <= ptr_step;
   end

   assign ptr_o = ptr_q;
endmodule

// File: rtl/twi_regslave.sv
module twi_regslave
   import twi_pkg::*;
#(
   parameter logic [6:0]        DEV_ADDR    = 7'b0110010,
   parameter int                ADDR_W      = 6,
   parameter int                GROUP_W     = 4,
   parameter logic [ADDR_W-1:0] RST_PTR     = 6'h10,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i
);
   localparam logic [3:0] BITS = 4'(BYTE_W);

   if (ADDR_W > BYTE_W) begin : g_bad_addr
      $error("twi_regslave pointer must fit in one byte");
   end

   logic       scl_s, sda_s;
   twi_evt_t   evt;
   twi_state_e state;
   logic [3:0] cnt;
   logic [7:0] shreg, txreg;
   logic       rw_q, mack_q, sda_oe;
   logic       byte_end, busy_evt, ptr_load, ptr_inc;
   logic [ADDR_W-1:0] ptr;

   twi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
   );

   twi_busmon i_busmon (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .evt_o(evt)
   );

   always_comb begin
      busy_evt = evt.start | evt.stop;
      byte_end = evt.scl_fall && (cnt == BITS) && !busy_evt;
      ptr_load = byte_end && (state == ST_PTR);
      ptr_inc  = byte_end && ((state == ST_WR) || (state == ST_RD));
   end

   twi_ptr #(.ADDR_W(ADDR_W), .GROUP_W(GROUP_W), .RST_PTR(RST_PTR)) i_ptr (
      .clk(clk), .rst_n(rst_n), .load_i(ptr_load),
      .load_val_i(shreg[ADDR_W-1:0]), .inc_i(ptr_inc), .ptr_o(ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         shreg     <= '0;
         txreg     <= '0;
         rw_q      <= 1'b0;
         mack_q    <= 1'b1;
         sda_oe    <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (evt.start) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (evt.stop) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_PTR, ST_WR: begin
                  if (evt.scl_rise && cnt != BITS) begin
                     shreg <= {shreg[6:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (byte_end) begin
                     cnt <= '0;
                     if (state == ST_ADDR) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           rw_q   <= shreg[0];
                           sda_oe <= 1'b1;
                           state  <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_PTR) begin
                        sda_oe <= 1'b1;
                        state  <= ST_PTR_ACK;
                     end else begin
                        wr_en_o   <= 1'b1;
                        wr_addr_o <= ptr;
                        wr_data_o <= shreg;
                        sda_oe    <= 1'b1;
                        state     <= ST_WR_ACK;
                     end
                  end
               end
               ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: begin
                  if (evt.scl_fall) begin
                     cnt <= '0;
                     if (state == ST_ADDR_ACK && rw_q) begin
                        txreg  <= rd_data_i;
                        sda_oe <= ~rd_data_i[7];
                        state  <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= (state == ST_ADDR_ACK) ? ST_PTR : ST_WR;
                     end
                  end
               end
               ST_RD: begin
                  if (evt.scl_rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (evt.scl_fall) begin
                     if (cnt == BITS) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RD_ACK;
                     end else begin
                        txreg  <= {txreg[6:0], 1'b0};
                        sda_oe <= ~txreg[6];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (evt.scl_rise) begin
                     mack_q <= sda_s;
                  end else if (evt.scl_fall) begin
                     cnt <= '0;
                     if (!mack_q) begin
                        txreg  <= rd_data_i;
                        sda_oe <= ~rd_data_i[7];
                        state  <= ST_RD;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o  = sda_oe;
   assign rd_addr_o = ptr;

   // R11: drive changes only while SCL is low, or as release on START/STOP
   a_r11_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(evt.start) || $past(evt.stop)));

   a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   a_r3_ack_driven: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK || state == ST_PTR_ACK || state == ST_WR_ACK) |-> sda_oe);

   a_r10_stop_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      $past(evt.stop) |-> (state == ST_IDLE && !wr_en_o));

   a_r10_full_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> ($past(state) == ST_WR && $past(cnt) == BITS));
endmodule

// File: tb/test_twi_regslave.sv
`timescale 1ns/1ps
module test_twi_regslave;
   localparam int Q = 10;
   localparam logic [7:0] AW = 8'h64;
   localparam logic [7:0] AR = 8'h65;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_o = 1'b1, sda_o = 1'b1;
   logic sda_oe, wr_en;
   logic [5:0] wr_addr, rd_addr;
   logic [7:0] wr_data, rd_data;
   wire  sda_line = sda_o & ~sda_oe;

   logic [7:0] mem [64];
   logic [7:0] exp_mem [64];
   logic [5:0] bptr;
   int n_tests = 0, n_fail = 0, wr_cnt = 0, r11_viol = 0;
   logic prev_oe = 1'b0;

   always #2 clk = ~clk;

   twi_regslave i_twi_regslave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_o), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
      .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
   );

   assign rd_data = mem[rd_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
         wr_cnt <= wr_cnt + 1;
      end
   end

   always @(posedge clk) begin
      prev_oe <= sda_oe;
      if (rst_n && scl_o && (sda_oe !== prev_oe)) r11_viol <= r11_viol + 1;
   end

   function automatic logic [5:0] nxt(input logic [5:0] p);
      return {p[5:4], p[3:0] + 4'd1};
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wq;
      repeat (Q) @(negedge clk);
   endtask

   task automatic m_start;
      sda_o = 1'b1; wq; scl_o = 1'b1; wq; sda_o = 1'b0; wq; scl_o = 1'b0; wq;
   endtask

   task automatic m_stop;
      sda_o = 1'b0; wq; scl_o = 1'b1; wq; sda_o = 1'b1; wq;
   endtask

   task automatic m_bit(input logic b, output logic r);
      sda_o = b; wq; scl_o = 1'b1; wq; r = sda_line; wq; scl_o = 1'b0; wq;
   endtask

   task automatic m_wbyte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) m_bit(b[i], r);
      m_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic m_rbyte(input logic nack, output logic [7:0] d);
      logic r;
      for (int i = 0; i < 8; i++) begin
         m_bit(1'b1, r);
         d = {d[6:0], r};
      end
      m_bit(nack, r);
   endtask

   task automatic write_data(input logic [7:0] d, input string req);
      logic ack;
      m_wbyte(d, ack);
      chk(req, "data ack", ack, 1);
      exp_mem[bptr] = d;
      bptr = nxt(bptr);
   endtask

   task automatic read_run(input int n, input string req);
      logic [7:0] d;
      for (int i = 0; i < n; i++) begin
         m_rbyte(i == n - 1, d);
         chk(req, $sformatf("read byte at %0h", bptr), d, exp_mem[bptr]);
         bptr = nxt(bptr);
      end
   endtask

   task automatic cur_read(input int n, input string req);
      logic ack;
      m_start;
      m_wbyte(AR, ack);
      chk("R1", "read address ack", ack, 1);
      read_run(n, req);
      m_stop;
   endtask

   task automatic t_reset;
      chk("R9", "sda released after reset", sda_oe, 0);
      chk("R9", "no strobe after reset", wr_en, 0);
      bptr = 6'h10;
      cur_read(1, "R9");
   endtask

   task automatic t_write_wrap;
      logic ack;
      int c0 = wr_cnt;
      m_start;
      m_wbyte(AW, ack);   chk("R1", "write address ack", ack, 1);
      m_wbyte(8'h1E, ack); chk("R2", "pointer ack", ack, 1);
      bptr = 6'h1E;
      write_data(8'h11, "R3");
      write_data(8'h22, "R3");
      write_data(8'h33, "R3");
      m_stop;
      chk("R3", "strobe count", wr_cnt - c0, 3);
      chk("R3", "mem 1E", mem[6'h1E], 8'h11);
      chk("R4", "mem 1F", mem[6'h1F], 8'h22);
      chk("R4", "wrap to 10", mem[6'h10], 8'h33);
      chk("R4", "mem 20 untouched", mem[6'h20], exp_mem[6'h20]);
   endtask

   task automatic t_random_read;
      logic ack;
      m_start;
      m_wbyte(AW, ack);
      m_wbyte(8'h2E, ack); chk("R2", "pointer ack", ack, 1);
      bptr = 6'h2E;
      m_start;
      m_wbyte(AR, ack); chk("R5", "repeated start read ack", ack, 1);
      read_run(3, "R5 R6 R4");
      m_stop;
   endtask

   task automatic t_nack_release;
      logic ack;
      logic [7:0] d;
      m_start;
      m_wbyte(AR, ack);
      read_run(1, "R8");
      m_rbyte(1'b1, d);
      chk("R7", "bus released after nack", d, 8'hFF);
      m_stop;
   endtask

   task automatic t_abort;
      logic ack, r;
      int c0 = wr_cnt;
      m_start;
      m_wbyte(AW, ack);
      m_wbyte(8'h05, ack);
      bptr = 6'h05;
      write_data(8'h77, "R3");
      m_bit(1'b1, r); m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b0, r);
      m_stop;
      chk("R10", "one strobe after stop abort", wr_cnt - c0, 1);
      chk("R10", "mem 06 untouched", mem[6'h06], exp_mem[6'h06]);
      cur_read(1, "R10");
      c0 = wr_cnt;
      m_start;
      m_wbyte(AW, ack);
      m_wbyte(8'h08, ack);
      bptr = 6'h08;
      m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r);
      m_start;
      m_wbyte(AR, ack); chk("R10", "read ack after start abort", ack, 1);
      read_run(1, "R10");
      m_stop;
      chk("R10", "no strobe after start abort", wr_cnt - c0, 0);
   endtask

   task automatic t_mismatch;
      logic ack;
      int c0 = wr_cnt;
      m_start;
      m_wbyte(8'h66, ack); chk("R1", "foreign address nack", ack, 0);
      m_wbyte(8'h3C, ack); chk("R1", "ignored byte nack", ack, 0);
      m_wbyte(8'h99, ack); chk("R1", "ignored byte nack", ack, 0);
      m_stop;
      chk("R1", "no strobe for foreign address", wr_cnt - c0, 0);
      cur_read(1, "R1");
   endtask

   task automatic t_high_bits;
      logic ack;
      m_start;
      m_wbyte(AW, ack);
      m_wbyte(8'hFA, ack); chk("R2", "pointer ack", ack, 1);
      bptr = 6'h3A;
      write_data(8'h5C, "R2");
      m_stop;
      chk("R2", "upper pointer bits ignored", mem[6'h3A], 8'h5C);
      m_start;
      m_wbyte(AW, ack);
      m_wbyte(8'h3F, ack);
      bptr = 6'h3F;
      write_data(8'hA1, "R3");
      write_data(8'hB2, "R3");
      m_stop;
      chk("R4", "mem 3F", mem[6'h3F], 8'hA1);
      chk("R4", "wrap to 30", mem[6'h30], 8'hB2);
      cur_read(1, "R8");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) exp_mem[i] = 8'(i * 7 + 3);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset;
      t_write_wrap;
      cur_read(2, "R8");
      t_random_read;
      t_nack_release;
      t_abort;
      t_mismatch;
      t_high_bits;
      chk("R11", "drive changes while SCL high", r11_viol, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule